// File: doc/BRIEF.md
# USB Control Transfer Stage Sequencer

This block is the device-side sequencer for control transfers on the default control pipe. A packet engine in front of it reports one event per cycle: a SETUP transaction with its eight-byte payload, an IN token, or an OUT data packet. Software sits behind it. The block keeps the request fields from the payload and works out the transfer type. It then moves through the setup, data and status stages and picks the handshake for each token. All handshakes, stages and interrupts are decided by the block itself.

Software steers the data and status responses through three controls. The first is a response selector (NAK, BUF or STALL). The second is a request-valid flag, which software must clear before it may answer. The third is a completion bit that lets the status stage finish. A new SETUP always wins: it abandons any transfer in progress and restarts the sequence for the newest request.

The setup payload arrives on `setup_vld`/`setup_data`. There is no ready signal, because the block accepts a payload in every cycle, including in the middle of a transfer, so the packet engine never sees back-pressure. The buffer state comes in as plain level inputs. Every output is registered. An event sampled at one clock edge shows up at the outputs right after that edge.

Top module: `usb_ctrl_stage`

## Requirements
- R1: Each event (SETUP, IN or OUT) produces exactly one `hs_vld` pulse in the cycle after it. A SETUP is always answered with ACK (code 0), whatever the stage or response selection, including STALL.
- R2: After reset the outputs are: `stage` IDLE (0), `req_valid` 0, `rsp_sel` NAK (0), `done_flag` 0, no interrupts. A SETUP sets `req_valid` to 1, forces `rsp_sel` to NAK, clears `done_flag` and moves `stage` to SETUP (1).
- R3: The SETUP payload is split into fields: bits 7:0 go to `req_type`, 15:8 to `req_code`, 31:16 to `req_value`, 47:32 to `req_index` and 63:48 to `req_length`.
- R4: `xfer_type` is set as follows. When `req_length` is 0 it is no-data (3). Otherwise bit 7 of `req_type` decides: 1 gives control read (1) and 0 gives control write (2). Before the first SETUP it is 0.
- R5: While `req_valid` is 1, a software write of BUF (1) is ignored and `sw_done_set` is ignored. `sw_valid_clr` clears the flag. Writes of NAK or STALL are always taken, and the selector code 3 is ignored.
- R6: In the data stage, handshakes depend on the selector. With BUF, an IN is answered with DATA (4) when `tx_full` is 1 and with NAK (1) otherwise. With BUF, an OUT is answered with ACK (0) when `rx_space` is 1 and with NAK otherwise. With NAK, both tokens are answered with NAK.
- R7: In high-speed mode (`hs_mode` = 1), an OUT that is accepted in the write data stage is answered with NYET (3) instead of ACK when `rx_room_next` is 0.
- R8: The status stage is entered by the token that runs against the data direction: IN for a write or no-data transfer (stage 4), OUT for a read (stage 5). Status tokens are answered with NAK until `done_flag` is 1. After that, an IN status token is answered with ZLP (5) and an OUT status token with ACK, and `stage` returns to IDLE.
- R9: A token that does not fit the stage order raises a one-cycle `seqerr_irq` pulse. Such a token is answered with STALL (2), forces `rsp_sel` to STALL and leaves `stage` unchanged. The misfits are: an IN in the setup stage of a write, an OUT in the setup stage of a read or no-data transfer, the wrong token in a status stage, and any token in IDLE.
- R10: Once `rsp_sel` is STALL, every data and status token is answered with STALL and software writes are ignored. Only the next SETUP sets the selector back to NAK.
- R11: `stage_irq` pulses for one cycle, together with the handshake, on each entry to a data stage (2 or 3), on each entry to a status stage (4 or 5), and on completion of the status stage.
- R12: A SETUP that arrives during any stage abandons the current transfer. The block restarts in stage SETUP with the new fields and transfer type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_vld | input | 1 | SETUP transaction received, with its payload |
| setup_data | input | 64 | Eight-byte setup payload, first byte in bits 7:0 |
| in_tok | input | 1 | IN token received |
| out_tok | input | 1 | OUT data packet received |
| hs_mode | input | 1 | Link running at high speed |
| tx_full | input | 1 | Transmit buffer holds a packet ready to send |
| rx_space | input | 1 | Receive buffer can take the current packet |
| rx_room_next | input | 1 | Receive buffer will still have room for another max-size packet |
| sw_rsp_wr | input | 1 | Software write strobe for the response selector |
| sw_rsp | input | 2 | Selector value: 0 NAK, 1 BUF, 2 STALL |
| sw_valid_clr | input | 1 | Software clears the request-valid flag |
| sw_done_set | input | 1 | Software sets the completion bit |
| hs_vld | output | 1 | Handshake decision valid this cycle |
| hs_code | output | 3 | 0 ACK, 1 NAK, 2 STALL, 3 NYET, 4 DATA, 5 ZLP |
| req_valid | output | 1 | New request not yet acknowledged by software |
| rsp_sel | output | 2 | Current response selector |
| done_flag | output | 1 | Completion bit |
| stage | output | 3 | 0 IDLE, 1 SETUP, 2 read data, 3 write data, 4 IN status, 5 OUT status |
| xfer_type | output | 2 | 0 none, 1 read, 2 write, 3 no-data |
| req_type | output | 8 | Request type byte |
| req_code | output | 8 | Request code byte |
| req_value | output | 16 | Value field |
| req_index | output | 16 | Index field |
| req_length | output | 16 | Length field |
| stage_irq | output | 1 | Stage-transition interrupt pulse |
| seqerr_irq | output | 1 | Sequence-error interrupt pulse |

## Verification
The bench runs one transfer of each type: a read with a nonzero length and direction bit set, a write with a nonzero length, and a zero-length request. This separates the three stage paths and the two status handshakes, ZLP and ACK. For a write, the buffer inputs are swept through full space, space without room for the next packet, and no space, in both speed modes, so that ACK, NYET and NAK can be told apart. Further runs cover a SETUP that lands mid-data-stage, tokens that run against the stage order, and software writes made while the valid flag or STALL is held. These show whether the block's preemption, sticky-STALL and write-masking rules act on their own or leak into each other.

// File: rtl/usb_ctrl_pkg.sv
package usb_ctrl_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned FIELD_W = 16;
  localparam int unsigned SETUP_W = 2 * BYTE_W + 3 * FIELD_W;
  localparam int unsigned STAGE_W = 3;
  localparam int unsigned HS_W    = 3;
  localparam int unsigned RSP_W   = 2;

  typedef enum logic [STAGE_W-1:0] {
    ST_IDLE = 3'd0, ST_SETUP = 3'd1, ST_DATA_IN = 3'd2,
    ST_DATA_OUT = 3'd3, ST_STAT_IN = 3'd4, ST_STAT_OUT = 3'd5
  } stage_e;

  typedef enum logic [HS_W-1:0] {
    HS_ACK = 3'd0, HS_NAK = 3'd1, HS_STALL = 3'd2,
    HS_NYET = 3'd3, HS_DATA = 3'd4, HS_ZLP = 3'd5
  } hs_e;

  typedef enum logic [1:0] {
    XF_NONE = 2'd0, XF_READ = 2'd1, XF_WRITE = 2'd2, XF_NODATA = 2'd3
  } xfer_e;

  localparam logic [RSP_W-1:0] RSP_NAK   = 2'd0;
  localparam logic [RSP_W-1:0] RSP_BUF   = 2'd1;
  localparam logic [RSP_W-1:0] RSP_STALL = 2'd2;

  // Packed so that the low byte of the payload lands in rtype.
  typedef struct packed {
    logic [FIELD_W-1:0] len;
    logic [FIELD_W-1:0] idx;
    logic [FIELD_W-1:0] val;
    logic [BYTE_W-1:0]  req;
    logic [BYTE_W-1:0]  rtype;
  } setup_t;

  function automatic xfer_e classify(setup_t s);
    if (s.len == '0)          return XF_NODATA;
    else if (s.rtype[BYTE_W-1]) return XF_READ;
    else                      return XF_WRITE;
  endfunction

  // Returns {misfit, next stage} for a token in the given stage.
  function automatic logic [STAGE_W:0] route(stage_e st, xfer_e t, logic is_in);
    logic   bad;
    stage_e nx;
    bad = 1'b0;
    nx  = st;
    case (st)
      ST_SETUP: begin
        if (is_in) begin
          if (t == XF_READ)        nx = ST_DATA_IN;
          else if (t == XF_NODATA) nx = ST_STAT_IN;
          else                     bad = 1'b1;
        end else begin
          if (t == XF_WRITE) nx = ST_DATA_OUT;
          else               bad = 1'b1;
        end
      end
      ST_DATA_IN:  nx  = is_in ? ST_DATA_IN : ST_STAT_OUT;
      ST_DATA_OUT: nx  = is_in ? ST_STAT_IN : ST_DATA_OUT;
      ST_STAT_IN:  bad = !is_in;
      ST_STAT_OUT: bad = is_in;
      default:     bad = 1'b1;
    endcase
    return {bad, nx};
  endfunction
endpackage

// File: rtl/usb_req_latch.sv
module usb_req_latch
  import usb_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap,
  input  logic [SETUP_W-1:0] payload,
  output setup_t             fields,
  output xfer_e              xfer
);
  setup_t incoming;
  assign incoming = setup_t'(payload);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fields <= '0;
      xfer   <= XF_NONE;
    end else if (cap) begin
      fields <= incoming;
      xfer   <= classify(incoming);
    end
  end
endmodule

// File: rtl/usb_rsp_regs.sv
module usb_rsp_regs
  import usb_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_hit,
  input  logic             seq_err,
  input  logic             wr,
  input  logic [RSP_W-1:0] wdata,
  input  logic             valid_clr,
  input  logic             done_set,
  output logic             req_valid,
  output logic [RSP_W-1:0] rsp_sel,
  output logic             done_flag
);
  logic wr_ok;

  // A write is taken only for a legal code, never out of STALL,
  // and never BUF while the request is still unacknowledged.
  always_comb begin
    wr_ok = wr && (rsp_sel != RSP_STALL) && (wdata != 2'd3);
    if (wdata == RSP_BUF && req_valid) wr_ok = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      rsp_sel   <= RSP_NAK;
      done_flag <= 1'b0;
    end else if (setup_hit) begin
      req_valid <= 1'b1;
      rsp_sel   <= RSP_NAK;
      done_flag <= 1'b0;
    end else begin
      if (seq_err)     rsp_sel <= RSP_STALL;
      else if (wr_ok)  rsp_sel <= wdata;
      if (valid_clr)   req_valid <= 1'b0;
      if (done_set && !req_valid) done_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/usb_stage_seq.sv
module usb_stage_seq
  import usb_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_hit,
  input  logic             in_tok,
  input  logic             out_tok,
  input  logic             hs_mode,
  input  logic             tx_full,
  input  logic             rx_space,
  input  logic             rx_room_next,
  input  xfer_e            xfer,
  input  logic [RSP_W-1:0] rsp_sel,
  input  logic             done_flag,
  output stage_e           stage_q,
  output logic             hs_vld_q,
  output hs_e              hs_q,
  output logic             stage_irq_q,
  output logic             seqerr_irq_q,
  output logic             seq_err_now
);
  stage_e           st_n, tgt;
  hs_e              hs_n;
  logic             vld_n, irq_n;
  logic [STAGE_W:0] rt;

  always_comb begin
    st_n        = stage_q;
    hs_n        = hs_q;
    vld_n       = 1'b0;
    irq_n       = 1'b0;
    seq_err_now = 1'b0;
    rt          = route(stage_q, xfer, in_tok);
    tgt         = stage_e'(rt[STAGE_W-1:0]);
    if (setup_hit) begin
      st_n  = ST_SETUP;
      hs_n  = HS_ACK;
      vld_n = 1'b1;
    end else if (in_tok || out_tok) begin
      vld_n = 1'b1;
      if (rt[STAGE_W]) begin
        hs_n        = HS_STALL;
        seq_err_now = 1'b1;
      end else begin
        st_n  = tgt;
        irq_n = (tgt != stage_q);
        if (rsp_sel == RSP_STALL) begin
          hs_n = HS_STALL;
        end else begin
          case (tgt)
            ST_DATA_IN:
              hs_n = (rsp_sel == RSP_BUF && tx_full) ? HS_DATA : HS_NAK;
            ST_DATA_OUT: begin
              if (rsp_sel == RSP_BUF && rx_space)
                hs_n = (hs_mode && !rx_room_next) ? HS_NYET : HS_ACK;
              else
                hs_n = HS_NAK;
            end
            ST_STAT_IN, ST_STAT_OUT: begin
              if (done_flag) begin
                hs_n  = (tgt == ST_STAT_IN) ? HS_ZLP : HS_ACK;
                st_n  = ST_IDLE;
                irq_n = 1'b1;
              end else begin
                hs_n = HS_NAK;
              end
            end
            default: hs_n = HS_NAK;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q      <= ST_IDLE;
      hs_q         <= HS_ACK;
      hs_vld_q     <= 1'b0;
      stage_irq_q  <= 1'b0;
      seqerr_irq_q <= 1'b0;
    end else begin
      stage_q      <= st_n;
      hs_q         <= hs_n;
      hs_vld_q     <= vld_n;
      stage_irq_q  <= irq_n;
      seqerr_irq_q <= seq_err_now;
    end
  end
endmodule

// File: rtl/usb_ctrl_stage.sv
module usb_ctrl_stage
  import usb_ctrl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                setup_vld,
  input  logic [SETUP_W-1:0]  setup_data,
  input  logic                in_tok,
  input  logic                out_tok,
  input  logic                hs_mode,
  input  logic                tx_full,
  input  logic                rx_space,
  input  logic                rx_room_next,
  input  logic                sw_rsp_wr,
  input  logic [RSP_W-1:0]    sw_rsp,
  input  logic                sw_valid_clr,
  input  logic                sw_done_set,
  output logic                hs_vld,
  output logic [HS_W-1:0]     hs_code,
  output logic                req_valid,
  output logic [RSP_W-1:0]    rsp_sel,
  output logic                done_flag,
  output logic [STAGE_W-1:0]  stage,
  output logic [1:0]          xfer_type,
  output logic [BYTE_W-1:0]   req_type,
  output logic [BYTE_W-1:0]   req_code,
  output logic [FIELD_W-1:0]  req_value,
  output logic [FIELD_W-1:0]  req_index,
  output logic [FIELD_W-1:0]  req_length,
  output logic                stage_irq,
  output logic                seqerr_irq
);
  setup_t fields;
  xfer_e  xfer;
  stage_e stage_q;
  hs_e    hs_q;
  logic   seq_err_now;

  usb_req_latch u_latch (
    .clk(clk), .rst_n(rst_n), .cap(setup_vld), .payload(setup_data),
    .fields(fields), .xfer(xfer)
  );

  usb_rsp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .setup_hit(setup_vld), .seq_err(seq_err_now),
    .wr(sw_rsp_wr), .wdata(sw_rsp), .valid_clr(sw_valid_clr),
    .done_set(sw_done_set), .req_valid(req_valid), .rsp_sel(rsp_sel),
    .done_flag(done_flag)
  );

  usb_stage_seq u_seq (
    .clk(clk), .rst_n(rst_n), .setup_hit(setup_vld), .in_tok(in_tok),
    .out_tok(out_tok), .hs_mode(hs_mode), .tx_full(tx_full),
    .rx_space(rx_space), .rx_room_next(rx_room_next), .xfer(xfer),
    .rsp_sel(rsp_sel), .done_flag(done_flag), .stage_q(stage_q),
    .hs_vld_q(hs_vld), .hs_q(hs_q), .stage_irq_q(stage_irq),
    .seqerr_irq_q(seqerr_irq), .seq_err_now(seq_err_now)
  );

  assign hs_code    = hs_q;
  assign stage      = stage_q;
  assign xfer_type  = xfer;
  assign req_type   = fields.rtype;
  assign req_code   = fields.req;
  assign req_value  = fields.val;
  assign req_index  = fields.idx;
  assign req_length = fields.len;
endmodule

// File: rtl/usb_ctrl_stage_chk.sv
module usb_ctrl_stage_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       setup_vld,
  input logic       in_tok,
  input logic       out_tok,
  input logic       hs_mode,
  input logic       hs_vld,
  input logic [2:0] hs_code,
  input logic       req_valid,
  input logic [1:0] rsp_sel,
  input logic       done_flag,
  input logic [2:0] stage,
  input logic       stage_irq,
  input logic       seqerr_irq
);
  p_token_hs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_vld || in_tok || out_tok) |=> hs_vld);
  p_quiet_hs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(setup_vld || in_tok || out_tok) |=> !hs_vld);
  p_setup_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
    setup_vld |=> hs_code == 3'd0);
  p_setup_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
    setup_vld |=> (req_valid && rsp_sel == 2'd0 && !done_flag && stage == 3'd1));
  p_no_buf_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> rsp_sel != 2'd1);
  p_done_acked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_flag |-> !req_valid);
  p_nyet_hs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_vld && hs_code == 3'd3) |-> ($past(hs_mode) && stage == 3'd3));
  p_zlp_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_vld && hs_code == 3'd5) |-> (stage == 3'd0 && stage_irq));
  p_seqerr_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seqerr_irq |-> (hs_vld && hs_code == 3'd2 && rsp_sel == 2'd2));
  p_stall_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_sel == 2'd2 && !setup_vld) |=> rsp_sel == 2'd2);
  p_irq_with_hs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stage_irq |-> (hs_vld && !seqerr_irq));
endmodule

bind usb_ctrl_stage usb_ctrl_stage_chk u_chk (
  .clk(clk), .rst_n(rst_n), .setup_vld(setup_vld), .in_tok(in_tok),
  .out_tok(out_tok), .hs_mode(hs_mode), .hs_vld(hs_vld), .hs_code(hs_code),
  .req_valid(req_valid), .rsp_sel(rsp_sel), .done_flag(done_flag),
  .stage(stage), .stage_irq(stage_irq), .seqerr_irq(seqerr_irq)
);

// File: tb/usb_ctrl_stage_tb.sv
`timescale 1ns/1ps
module usb_ctrl_stage_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        setup_vld = 0, in_tok = 0, out_tok = 0, hs_mode = 0;
  logic        tx_full = 0, rx_space = 0, rx_room_next = 0;
  logic        sw_rsp_wr = 0, sw_valid_clr = 0, sw_done_set = 0;
  logic [1:0]  sw_rsp = 0;
  logic [63:0] setup_data = 0;
  logic        hs_vld, req_valid, done_flag, stage_irq, seqerr_irq;
  logic [2:0]  hs_code, stage;
  logic [1:0]  rsp_sel, xfer_type;
  logic [7:0]  req_type, req_code;
  logic [15:0] req_value, req_index, req_length;

  always #2.5 clk = ~clk;

  usb_ctrl_stage u_dut (.*);

  int checks = 0, errors = 0;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: integers, stage codes as numbers.
  int m_stage = 0, m_valid = 0, m_pid = 0, m_ccpl = 0, m_type = 0;
  int m_hsv = 0, m_hs = 0, m_si = 0, m_ei = 0;
  logic [63:0] m_setup = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stage = 0; m_valid = 0; m_pid = 0; m_ccpl = 0; m_type = 0;
      m_hsv = 0; m_hs = 0; m_si = 0; m_ei = 0; m_setup = 0;
    end else begin
      int nst, npid, nval, nccpl;
      bit bad;
      nst = m_stage; npid = m_pid; nval = m_valid; nccpl = m_ccpl;
      bad = 0; m_hsv = 0; m_si = 0; m_ei = 0;
      if (setup_vld) begin
        m_setup = setup_data;
        m_type  = (setup_data[63:48] == 0) ? 3 : (setup_data[7] ? 1 : 2);
        nst = 1; nval = 1; npid = 0; nccpl = 0; m_hsv = 1; m_hs = 0;
      end else begin
        if (in_tok || out_tok) begin
          m_hsv = 1;
          if (m_stage == 1 && in_tok && m_type == 1)       nst = 2;
          else if (m_stage == 1 && in_tok && m_type == 3)  nst = 4;
          else if (m_stage == 1 && out_tok && m_type == 2) nst = 3;
          else if (m_stage == 2)                           nst = in_tok ? 2 : 5;
          else if (m_stage == 3)                           nst = out_tok ? 3 : 4;
          else if (m_stage == 4 && in_tok)                 nst = 4;
          else if (m_stage == 5 && out_tok)                nst = 5;
          else bad = 1;
          if (bad) begin
            m_hs = 2; m_ei = 1;
          end else begin
            m_si = (nst != m_stage);
            if (m_pid == 2) m_hs = 2;
            else if (nst == 2) m_hs = (m_pid == 1 && tx_full) ? 4 : 1;
            else if (nst == 3)
              m_hs = (m_pid == 1 && rx_space) ? ((hs_mode && !rx_room_next) ? 3 : 0) : 1;
            else if (m_ccpl != 0) begin
              m_hs = (nst == 4) ? 5 : 0; nst = 0; m_si = 1;
            end else m_hs = 1;
          end
        end
        if (bad) npid = 2;
        else if (sw_rsp_wr && m_pid != 2 && sw_rsp != 3 && !(sw_rsp == 1 && m_valid != 0))
          npid = int'(sw_rsp);
        if (sw_valid_clr) nval = 0;
        if (sw_done_set && m_valid == 0) nccpl = 1;
      end
      m_stage = nst; m_pid = npid; m_valid = nval; m_ccpl = nccpl;
    end
  end

  // Compare against the reference on every cycle, away from the edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 hs_vld", hs_vld, m_hsv);
      if (m_hsv != 0) chk("R6 hs_code", hs_code, m_hs);
      chk("R8 stage", stage, m_stage);
      chk("R2 req_valid", req_valid, m_valid);
      chk("R10 rsp_sel", rsp_sel, m_pid);
      chk("R5 done_flag", done_flag, m_ccpl);
      chk("R11 stage_irq", stage_irq, m_si);
      chk("R9 seqerr_irq", seqerr_irq, m_ei);
      chk("R4 xfer_type", xfer_type, m_type);
      chk("R3 fields", {req_length, req_index, req_value, req_code, req_type}, m_setup);
    end
  end

  task automatic do_setup(logic [7:0] rt, logic [7:0] rq, logic [15:0] v,
                          logic [15:0] ix, logic [15:0] ln);
    @(negedge clk); setup_data = {ln, ix, v, rq, rt}; setup_vld = 1;
    @(negedge clk); setup_vld = 0;
  endtask
  task automatic do_in();  @(negedge clk); in_tok = 1;  @(negedge clk); in_tok = 0;  endtask
  task automatic do_out(); @(negedge clk); out_tok = 1; @(negedge clk); out_tok = 0; endtask
  task automatic do_rsp(logic [1:0] v);
    @(negedge clk); sw_rsp = v; sw_rsp_wr = 1; @(negedge clk); sw_rsp_wr = 0;
  endtask
  task automatic do_clr();  @(negedge clk); sw_valid_clr = 1; @(negedge clk); sw_valid_clr = 0; endtask
  task automatic do_done(); @(negedge clk); sw_done_set = 1;  @(negedge clk); sw_done_set = 0;  endtask

  initial begin
    #(5.0 * 20000);
    chk("watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R2 reset stage", stage, 0);
    chk("R2 reset valid", req_valid, 0);
    chk("R2 reset rsp", rsp_sel, 0);

    // Control read
    do_setup(8'h80, 8'h06, 16'h0100, 16'h0000, 16'd18);
    chk("R1 setup ack", hs_code, 0);
    chk("R3 req_code", req_code, 8'h06);
    chk("R3 req_length", req_length, 18);
    chk("R4 read type", xfer_type, 1);
    do_rsp(2'd1);
    chk("R5 BUF ignored while valid", rsp_sel, 0);
    do_done();
    chk("R5 done ignored while valid", done_flag, 0);
    do_clr();
    do_rsp(2'd1);
    chk("R5 BUF taken after clear", rsp_sel, 1);
    do_in();
    chk("R6 IN empty NAK", hs_code, 1);
    chk("R11 data entry irq", stage_irq, 1);
    tx_full = 1;
    do_in();
    chk("R6 IN full DATA", hs_code, 4);
    chk("R11 no irq inside stage", stage_irq, 0);
    do_out();
    chk("R8 status OUT entry", stage, 5);
    chk("R8 status NAK before done", hs_code, 1);
    do_done();
    do_out();
    chk("R8 status ACK", hs_code, 0);
    chk("R8 back to idle", stage, 0);
    chk("R11 completion irq", stage_irq, 1);
    tx_full = 0;

    // Control write, high speed
    do_setup(8'h00, 8'h09, 16'h0001, 16'h0002, 16'd64);
    chk("R4 write type", xfer_type, 2);
    do_clr(); do_rsp(2'd1);
    hs_mode = 1; rx_space = 1; rx_room_next = 1;
    do_out();
    chk("R6 OUT ACK", hs_code, 0);
    rx_room_next = 0;
    do_out();
    chk("R7 NYET when no room", hs_code, 3);
    rx_space = 0;
    do_out();
    chk("R6 OUT no space NAK", hs_code, 1);
    hs_mode = 0; rx_space = 1;
    do_out();
    chk("R7 full speed ACK", hs_code, 0);
    do_in();
    chk("R8 status IN entry", stage, 4);
    do_done();
    do_in();
    chk("R8 status ZLP", hs_code, 5);

    // No-data with wrong-direction token
    do_setup(8'h00, 8'h05, 16'h0007, 16'h0000, 16'd0);
    chk("R4 no-data type", xfer_type, 3);
    do_out();
    chk("R9 seqerr pulse", seqerr_irq, 1);
    chk("R9 stall reply", hs_code, 2);
    chk("R9 stage kept", stage, 1);
    do_clr(); do_rsp(2'd0);
    chk("R10 write ignored in STALL", rsp_sel, 2);
    do_in();
    chk("R10 status STALL", hs_code, 2);
    do_setup(8'h00, 8'h05, 16'h0007, 16'h0000, 16'd0);
    chk("R10 setup clears STALL", rsp_sel, 0);
    do_clr(); do_in();
    chk("R8 no-data status NAK", hs_code, 1);
    do_done(); do_in();
    chk("R8 no-data ZLP", hs_code, 5);
    do_in();
    chk("R9 token in idle", seqerr_irq, 1);

    // Mid-transfer SETUP
    do_setup(8'h80, 8'h06, 16'h0200, 16'h0000, 16'd9);
    do_clr(); do_rsp(2'd1); do_in();
    chk("R12 in read data", stage, 2);
    do_setup(8'h21, 8'h09, 16'h0300, 16'h0001, 16'd7);
    chk("R12 restart stage", stage, 1);
    chk("R12 new type", xfer_type, 2);
    chk("R12 valid again", req_valid, 1);
    chk("R12 rsp back to NAK", rsp_sel, 0);
    do_in();
    chk("R9 IN in write setup", seqerr_irq, 1);
    do_setup(8'h21, 8'h09, 16'h0300, 16'h0001, 16'd7);
    chk("R1 setup ack after STALL", hs_code, 0);

    // Software STALL during write data
    do_clr(); do_rsp(2'd1); do_out();
    do_rsp(2'd2);
    do_out();
    chk("R10 data STALL", hs_code, 2);
    do_in();
    chk("R10 status STALL", hs_code, 2);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule